// File: doc/BRIEF.md
# Quad-Rate Burst-of-Four SRAM Model

This block is a synthesizable behavioural stand-in for a quad-data-rate static memory with a fixed burst of four words. It lets a memory controller be checked in simulation against a memory that follows the same command, burst and latency rules as the real device, without any electrical detail. Reads and writes use separate data paths, so a read and a write may be started on the same clock edge. Each clock cycle carries two data beats. The first beat is presented on the "rise" port and the second on the "fall" port.

A command is taken on the rising clock edge. A low read request starts a four-word read burst. A low write request starts a four-word write burst. Write data follows over the next two cycles and has a per-beat, per-byte-lane mask. Read data comes back over the two cycles that follow the command, together with a drive flag. When that flag is low, the output stands for high impedance. The storage is a shallow register array of 64 words by default. The burst offset wraps inside an aligned group of four words.

Top module: `qdr4_sram_model`

## Requirements
- R1: With both request inputs high at a clock edge, nothing is started. The array keeps its contents whatever appears on the write data and mask inputs, and no read beat appears.
- R2: A write accepted at edge E stores four words. The rise and fall beats sampled at edge E+1 go to burst offsets 0 and 1. The rise and fall beats sampled at edge E+2 go to offsets 2 and 3.
- R3: A read accepted at edge E drives offsets 0 and 1 on the rise and fall outputs during the cycle after edge E+1. It drives offsets 2 and 3 during the cycle after edge E+2. The drive output is 1 in both of those cycles.
- R4: A request of one type at the edge right after an accepted request of the same type is ignored. A read and a write may be accepted at the same edge.
- R5: Mask bits are active low and apply to each beat on its own. Mask bit 0 low updates data bits 8:0 and mask bit 1 low updates bits 17:9. With both mask bits high, the stored word is left as it was.
- R6: Whenever no read beat is being delivered, including during reset and right after it, the drive output is 0 and both read data outputs are all zeros.
- R7: A read and a write to the same address accepted at the same edge return the words stored before that write.
- R8: The word at burst offset k is at address {A[5:2], (A[1:0]+k) mod 4}. The upper address bits never change within a burst, so a burst started at 62 touches 62, 63, 60 and 61.
- R9: Reset clears any memory of an earlier command, so the first request seen after reset is accepted even if it was held low through reset. Reset leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands and data are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req_n | input | 1 | Active-low read request |
| wr_req_n | input | 1 | Active-low write request |
| cmd_addr | input | 6 | Burst start address |
| wd_rise | input | 18 | First write beat of the cycle |
| wd_fall | input | 18 | Second write beat of the cycle |
| wmask_rise_n | input | 2 | Active-low lane mask for the first beat |
| wmask_fall_n | input | 2 | Active-low lane mask for the second beat |
| rq_rise | output | 18 | First read beat of the cycle |
| rq_fall | output | 18 | Second read beat of the cycle |
| rq_drive | output | 1 | 1 while read beats are delivered; 0 stands for high impedance |

## Verification
Counting the command edge as E, a write's beat pairs are sampled at E+1 and E+2. A read's beat pairs become visible after E+1 and after E+2, so they are due two and three cycles after the command. The driver pushes each expected beat pair into a queue, tagged with the absolute cycle in which it is due. The monitor samples on the falling edge and compares each pair in exactly that cycle. In every other cycle it requires the drive output to be 0 and both data outputs to be zero. This also catches an ignored back-to-back read that wrongly produced data. An ignored back-to-back write is caught by reading its target address back later.

// File: rtl/qdr4_pkg.sv
// Package qdr4_pkg
// Shared constants for the burst-of-four quad-rate memory model.
// Assumes the burst length and the beats per cycle are fixed by the device
// class; the pipeline depth of the burst sequencer derives from them.
package qdr4_pkg;
    localparam int BURST_LEN       = 4;
    localparam int BEATS_PER_CYCLE = 2;
    localparam int PAIR_PHASES     = BURST_LEN / BEATS_PER_CYCLE;
    localparam int OFS_W           = $clog2(BURST_LEN);

    // Which half of the burst a beat pair carries
    typedef enum logic [0:0] {
        PAIR_LOW  = 1'b0,
        PAIR_HIGH = 1'b1
    } pair_e;
endpackage

// File: rtl/qdr4_cmd_gate.sv
// Module qdr4_cmd_gate
// Turns an active-low request into a one-cycle accept pulse. A request on
// the edge right after an accepted one is dropped. Reset forgets the
// previous accept, so the first request after reset always passes.
// Assumes one instance per command type.
module qdr4_cmd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    output logic accept
);
    logic took_last;

    // Accept a request only if the previous edge accepted none of this type
    always_comb begin
        accept = rst_n && !req_n && !took_last;
    end

    // Remember whether this edge accepted a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            took_last <= 1'b0;
        end else begin
            took_last <= accept;
        end
    end

    // R4: two accepts of one type never sit on adjacent edges
    p_no_repeat_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept)
        else $error("p_no_repeat_accept_r4");

    // R9: the first request after reset is taken
    p_first_after_reset_r9: assert property (@(posedge clk)
        (rst_n && !req_n && $past(!rst_n)) |-> accept)
        else $error("p_first_after_reset_r9");
endmodule

// File: rtl/qdr4_burst_seq.sv
// Module qdr4_burst_seq
// Walks an accepted burst through its beat-pair phases, one phase per
// cycle after the command edge. Produces the two beat addresses of the
// active phase. The offset wraps inside the aligned group of four.
// Assumes starts are at least two cycles apart, which the command gate
// guarantees for one command type.
module qdr4_burst_seq
    import qdr4_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    output logic          pair_vld,
    output pair_e         pair_sel,
    output logic [AW-1:0] addr_rise,
    output logic [AW-1:0] addr_fall
);
    logic [PAIR_PHASES-1:0] phase_q;
    logic [AW-1:0]          base_q;
    logic [OFS_W-1:0]       ofs_rise;
    logic [OFS_W-1:0]       ofs_fall;

    // Advance the phase shift register and capture the burst base address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            base_q  <= '0;
        end else begin
            phase_q <= {phase_q[PAIR_PHASES-2:0], start};
            if (start) begin
                base_q <= start_addr;
            end
        end
    end

    // Decode the active phase into a pair selector
    always_comb begin
        pair_vld = |phase_q;
        pair_sel = phase_q[PAIR_PHASES-1] ? PAIR_HIGH : PAIR_LOW;
    end

    // Compute the wrapped burst offsets of the two beats in this phase
    always_comb begin
        ofs_rise = OFS_W'(base_q[OFS_W-1:0] + OFS_W'(BEATS_PER_CYCLE * int'(pair_sel)));
        ofs_fall = OFS_W'(ofs_rise + OFS_W'(1));
        addr_rise = {base_q[AW-1:OFS_W], ofs_rise};
        addr_fall = {base_q[AW-1:OFS_W], ofs_fall};
    end

    // R4: the ignore rule keeps bursts from overlapping in the sequencer
    p_phase_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_q))
        else $error("p_phase_single_r4");
endmodule

// File: rtl/qdr4_mem_array.sv
// Module qdr4_mem_array
// Register storage split into byte lanes. Each cycle it has two write
// ports (one per beat) with per-lane enables and two read ports with
// combinational data. Contents are not reset.
// Assumes the two beats of a cycle never address the same word.
module qdr4_mem_array #(
    parameter int AW     = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_rise,
    input  logic [LANES-1:0]        lane_en_rise,
    input  logic [AW-1:0]           wa_rise,
    input  logic [LANES*LANE_W-1:0] wd_rise,
    input  logic                    we_fall,
    input  logic [LANES-1:0]        lane_en_fall,
    input  logic [AW-1:0]           wa_fall,
    input  logic [LANES*LANE_W-1:0] wd_fall,
    input  logic [AW-1:0]           ra_rise,
    input  logic [AW-1:0]           ra_fall,
    output logic [LANES*LANE_W-1:0] rd_rise,
    output logic [LANES*LANE_W-1:0] rd_fall
);
    localparam int DEPTH = 1 << AW;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        // Write the enabled lane of each beat into this lane's storage
        always_ff @(posedge clk) begin
            if (we_rise && lane_en_rise[ln]) begin
                store[wa_rise] <= wd_rise[ln*LANE_W +: LANE_W];
            end
            if (we_fall && lane_en_fall[ln]) begin
                store[wa_fall] <= wd_fall[ln*LANE_W +: LANE_W];
            end
        end

        // Read this lane for both beats
        always_comb begin
            rd_rise[ln*LANE_W +: LANE_W] = store[ra_rise];
            rd_fall[ln*LANE_W +: LANE_W] = store[ra_fall];
        end
    end

    // R8: the two beats of one cycle land on distinct wrapped addresses
    p_beats_distinct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_rise && we_fall) |-> (wa_rise != wa_fall))
        else $error("p_beats_distinct_r8");
endmodule

// File: rtl/qdr4_rd_out.sv
// Module qdr4_rd_out
// Output register for read beats. It holds a beat pair for one cycle and
// raises the drive flag. Outside a delivered pair it forces zeros with
// the flag low, which stands for high impedance.
// Assumes load is high exactly in the cycles whose pair should appear next.
module qdr4_rd_out #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] d_rise,
    input  logic [DW-1:0] d_fall,
    output logic [DW-1:0] q_rise,
    output logic [DW-1:0] q_fall,
    output logic          drive
);
    // Capture a beat pair or return to the quiet state
    always_ff @(posedge clk) begin
        if (!rst_n || !load) begin
            q_rise <= '0;
            q_fall <= '0;
            drive  <= 1'b0;
        end else begin
            q_rise <= d_rise;
            q_fall <= d_fall;
            drive  <= 1'b1;
        end
    end

    // R6: the output is quiet in the cycle after any reset edge
    p_reset_quiet_r6: assert property (@(posedge clk)
        !rst_n |=> (!drive && q_rise == '0 && q_fall == '0))
        else $error("p_reset_quiet_r6");
endmodule

// File: rtl/qdr4_sram_model.sv
// Module qdr4_sram_model
// Behavioural burst-of-four quad-rate memory. It has separate read and
// write command gates, a beat-pair sequencer per direction, byte-lane
// storage and a registered read output.
// Assumes a 4-word burst and two beats per cycle. Reads of a word see the
// array as it was before the edge that launches that word.
module qdr4_sram_model
    import qdr4_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_req_n,
    input  logic                    wr_req_n,
    input  logic [AW-1:0]           cmd_addr,
    input  logic [LANES*LANE_W-1:0] wd_rise,
    input  logic [LANES*LANE_W-1:0] wd_fall,
    input  logic [LANES-1:0]        wmask_rise_n,
    input  logic [LANES-1:0]        wmask_fall_n,
    output logic [LANES*LANE_W-1:0] rq_rise,
    output logic [LANES*LANE_W-1:0] rq_fall,
    output logic                    rq_drive
);
    localparam int DW = LANES * LANE_W;

    logic          rd_acc, wr_acc;
    logic          w_act, r_act;
    pair_e         w_sel, r_sel;
    logic [AW-1:0] w_ar, w_af, r_ar, r_af;
    logic [DW-1:0] mem_rr, mem_rf;

    qdr4_cmd_gate u_rd_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_n  (rd_req_n),
        .accept (rd_acc)
    );

    qdr4_cmd_gate u_wr_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_n  (wr_req_n),
        .accept (wr_acc)
    );

    qdr4_burst_seq #(.AW(AW)) u_wr_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (wr_acc),
        .start_addr (cmd_addr),
        .pair_vld   (w_act),
        .pair_sel   (w_sel),
        .addr_rise  (w_ar),
        .addr_fall  (w_af)
    );

    qdr4_burst_seq #(.AW(AW)) u_rd_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (rd_acc),
        .start_addr (cmd_addr),
        .pair_vld   (r_act),
        .pair_sel   (r_sel),
        .addr_rise  (r_ar),
        .addr_fall  (r_af)
    );

    qdr4_mem_array #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_rise      (w_act),
        .lane_en_rise (~wmask_rise_n),
        .wa_rise      (w_ar),
        .wd_rise      (wd_rise),
        .we_fall      (w_act),
        .lane_en_fall (~wmask_fall_n),
        .wa_fall      (w_af),
        .wd_fall      (wd_fall),
        .ra_rise      (r_ar),
        .ra_fall      (r_af),
        .rd_rise      (mem_rr),
        .rd_fall      (mem_rf)
    );

    qdr4_rd_out #(.DW(DW)) u_rd_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (r_act),
        .d_rise (mem_rr),
        .d_fall (mem_rf),
        .q_rise (rq_rise),
        .q_fall (rq_fall),
        .drive  (rq_drive)
    );

    // R2: a write's high pair follows its low pair on the next edge
    p_wr_pair_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (w_act && w_sel == PAIR_LOW) |=> (w_act && w_sel == PAIR_HIGH))
        else $error("p_wr_pair_order_r2");

    // R3: an accepted read drives beats two and three cycles later
    p_rd_first_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |-> ##2 rq_drive)
        else $error("p_rd_first_pair_r3");

    p_rd_second_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |-> ##3 rq_drive)
        else $error("p_rd_second_pair_r3");

    // R6: read beats appear only when a read sequence was active an edge before
    p_drive_only_for_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rq_drive |-> $past(r_act))
        else $error("p_drive_only_for_reads_r6");
endmodule

// File: tb/qdr4_sram_model_tb_top.sv
// Scoreboard bench for qdr4_sram_model. The driver tasks keep a shadow
// of the array and push expected read pairs tagged with their due cycle.
// The monitor compares them on the falling edge.
module qdr4_sram_model_tb_top;
    localparam int AW = 6;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req_n = 1'b1;
    logic          wr_req_n = 1'b1;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] wd_rise = '0;
    logic [DW-1:0] wd_fall = '0;
    logic [1:0]    wmask_rise_n = 2'b11;
    logic [1:0]    wmask_fall_n = 2'b11;
    logic [DW-1:0] rq_rise, rq_fall;
    logic          rq_drive;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    logic [DW-1:0] sh [1<<AW];
    int            due_q [$];
    logic [2*DW-1:0] val_q [$];
    string         tag_q [$];

    qdr4_sram_model dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req_n     (rd_req_n),
        .wr_req_n     (wr_req_n),
        .cmd_addr     (cmd_addr),
        .wd_rise      (wd_rise),
        .wd_fall      (wd_fall),
        .wmask_rise_n (wmask_rise_n),
        .wmask_fall_n (wmask_fall_n),
        .rq_rise      (rq_rise),
        .rq_fall      (rq_fall),
        .rq_drive     (rq_drive)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [AW-1:0] wrap(input logic [AW-1:0] a, input int k);
        return {a[AW-1:2], 2'(a[1:0] + 2'(k))};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [1:0] m);
        logic [DW-1:0] r;
        r = old_w;
        if (!m[0]) r[8:0]  = new_w[8:0];
        if (!m[1]) r[17:9] = new_w[17:9];
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'(a * 1021 + k * 37 + 18'h15a5);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Monitor: compare due pairs; demand a quiet output otherwise
    always @(negedge clk) begin
        if (mon_en && !done) begin
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                check(rq_drive === 1'b1 && {rq_rise, rq_fall} === val_q[0], tag_q[0],
                      {27'd0, rq_drive, rq_rise, rq_fall}, {28'd1, val_q[0]});
                void'(due_q.pop_front());
                void'(val_q.pop_front());
                void'(tag_q.pop_front());
            end else begin
                check(rq_drive === 1'b0 && rq_rise === '0 && rq_fall === '0, "R6 quiet",
                      {27'd0, rq_drive, rq_rise, rq_fall}, 64'd0);
            end
        end
    end

    // Queue the two pairs of a read of base a, seen from the shadow now
    task automatic push_read(input logic [AW-1:0] a, input string tag);
        for (int p = 0; p < 2; p++) begin
            due_q.push_back(cyc + 2 + p);
            val_q.push_back({sh[wrap(a, 2*p)], sh[wrap(a, 2*p+1)]});
            tag_q.push_back(tag);
        end
    endtask

    task automatic issue(input bit rd, input bit wr, input logic [AW-1:0] a,
                         input string tag);
        @(negedge clk);
        rd_req_n = !rd;
        wr_req_n = !wr;
        cmd_addr = a;
        wd_rise = '0;
        wd_fall = '0;
        wmask_rise_n = 2'b11;
        wmask_fall_n = 2'b11;
        if (rd) push_read(a, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_req_n = 1'b1;
            wr_req_n = 1'b1;
            wmask_rise_n = 2'b11;
            wmask_fall_n = 2'b11;
        end
    endtask

    task automatic data_beats(input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                              input logic [1:0] m0, input logic [1:0] m1);
        wd_rise = d0;
        wd_fall = d1;
        wmask_rise_n = m0;
        wmask_fall_n = m1;
    endtask

    task automatic shadow_write(input logic [AW-1:0] a, input logic [DW-1:0] d [4],
                                input logic [1:0] m [4]);
        for (int k = 0; k < 4; k++) sh[wrap(a, k)] = merge(sh[wrap(a, k)], d[k], m[k]);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d [4],
                            input logic [1:0] m [4], input bit rd_too, input string tag);
        issue(rd_too, 1'b1, a, tag);
        @(negedge clk);
        rd_req_n = 1'b1;
        wr_req_n = 1'b1;
        data_beats(d[0], d[1], m[0], m[1]);
        @(negedge clk);
        data_beats(d[2], d[3], m[2], m[3]);
        shadow_write(a, d, m);
    endtask

    task automatic full_write(input logic [AW-1:0] a);
        logic [DW-1:0] d [4];
        logic [1:0]    m [4];
        for (int k = 0; k < 4; k++) begin
            d[k] = pat(int'(a), k);
            m[k] = 2'b00;
        end
        do_write(a, d, m, 1'b0, "R2");
    endtask

    initial begin
        logic [DW-1:0] d [4];
        logic [1:0]    m [4];
        for (int i = 0; i < (1 << AW); i++) sh[i] = '0;

        // Reset with a read request held low (R6 during reset)
        rd_req_n = 1'b0;
        @(posedge clk);
        mon_en = 1'b1;
        idle(0);
        repeat (3) @(negedge clk);
        rd_req_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        check(rq_drive === 1'b0, "R6 after reset", {63'd0, rq_drive}, 64'd0);

        // R2/R3: aligned write then read
        full_write(6'd8);
        issue(1'b1, 1'b0, 6'd8, "R2 R3 aligned read");
        idle(4);

        // R8: unaligned write at 13 read back from 12, and a top-of-array burst
        full_write(6'd13);
        issue(1'b1, 1'b0, 6'd12, "R8 wrap 13");
        idle(4);
        full_write(6'd62);
        issue(1'b1, 1'b0, 6'd60, "R8 wrap 62");
        idle(4);

        // R5: per-beat masks over the words at 8..11
        for (int k = 0; k < 4; k++) d[k] = 18'h3ffff ^ DW'(k * 3);
        m[0] = 2'b10; m[1] = 2'b01; m[2] = 2'b11; m[3] = 2'b00;
        do_write(6'd8, d, m, 1'b0, "R5");
        issue(1'b1, 1'b0, 6'd8, "R5 masked read");
        idle(4);

        // R1: idle cycles with live write data and open masks change nothing
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rd_req_n = 1'b1;
            wr_req_n = 1'b1;
            data_beats(18'h2aaaa, 18'h15555, 2'b00, 2'b00);
        end
        issue(1'b1, 1'b0, 6'd12, "R1 nop kept 12");
        idle(1);
        issue(1'b1, 1'b0, 6'd8, "R1 nop kept 8");
        idle(4);

        // R7: same-edge read and write of 20 return the old words, then the new
        full_write(6'd20);
        for (int k = 0; k < 4; k++) begin
            d[k] = pat(99, k);
            m[k] = 2'b00;
        end
        do_write(6'd20, d, m, 1'b1, "R7 old data");
        idle(3);
        issue(1'b1, 1'b0, 6'd20, "R7 new data");
        idle(4);

        // R4: a second read on the next edge is ignored
        full_write(6'd40);
        issue(1'b1, 1'b0, 6'd40, "R4 first read");
        @(negedge clk);
        rd_req_n = 1'b0;
        cmd_addr = 6'd12;
        idle(5);

        // R4: a second write on the next edge is ignored (44 must keep its data)
        full_write(6'd44);
        for (int k = 0; k < 4; k++) begin
            d[k] = pat(7, k);
            m[k] = 2'b00;
        end
        issue(1'b0, 1'b1, 6'd40, "R4");
        @(negedge clk);
        wr_req_n = 1'b0;
        cmd_addr = 6'd44;
        data_beats(d[0], d[1], m[0], m[1]);
        @(negedge clk);
        wr_req_n = 1'b1;
        data_beats(d[2], d[3], m[2], m[3]);
        shadow_write(6'd40, d, m);
        issue(1'b1, 1'b0, 6'd44, "R4 ignored write");
        idle(1);
        issue(1'b1, 1'b0, 6'd40, "R4 accepted write");
        idle(1);
        // R3: back-to-back deliveries with one idle edge between reads
        issue(1'b1, 1'b0, 6'd8, "R3 gap read");
        idle(4);

        // R9: reset mid-run with a read held low; first edge after reset is taken
        @(negedge clk);
        rst_n = 1'b0;
        rd_req_n = 1'b0;
        cmd_addr = 6'd20;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push_read(6'd20, "R9 first after reset");
        @(negedge clk);
        rd_req_n = 1'b1;
        idle(5);

        check(due_q.size() == 0, "R3 all pairs delivered", 64'(due_q.size()), 64'd0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule